// File: doc/BRIEF.md
# Local Bus Strobe Generator

This block bridges a synchronous local bus and a slow 16-bit asynchronous peripheral. A bus master opens a transfer by pulling the address strobe low for one clock. It presents a 16-bit word address, a direction bit and a strobe-length value alongside it. The block decodes the address into one of three regions:
- the peripheral page;
- an internal latch word;
- an internal input-buffer word.

It then drives the matching active-low chip select together with either the read or the write strobe. Every output comes from a register clocked by the local bus clock.

The strobes stay low for the programmed number of clock cycles. They are released only once the burst-last signal has also been sampled low, and it may arrive before or after that time has run out. On the edge that releases the strobes, a one-cycle ready pulse goes back to the master. If an address hits no region, the block drives no strobe at all but still returns ready, so the master is never left waiting.

Top module: `lbus_strobe_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a clock edge, all three chip selects and both `rd_n` and `wr_n` are driven high after that edge, and `ready` is driven low.
- R2: When idle, `ads_n` sampled low at a clock edge starts a cycle. The selected chip select and strobe are low directly after that same edge.
- R3: Address decode works as follows:
  - `addr[15:12]` equal to `PER_PAGE` selects `per_cs_n`.
  - `addr == LATCH_ADDR` selects `latch_cs_n`.
  - `addr == INBUF_ADDR` selects `inbuf_cs_n`.
  - Any other address asserts no chip select and no read or write strobe, but still completes with `ready`.
- R4: `wr_rd` = 1 at the starting edge gives `wr_n` low; `wr_rd` = 0 gives `rd_n` low. The two strobes are never low together.
- R5: When `blast_n` has been sampled low at or before the strobe time runs out, chip select and strobe stay low for exactly `hold_cycles` clock cycles. A `hold_cycles` of 0 counts as 1.
- R6: When `blast_n` has not yet been sampled low by the time the strobe time runs out, the strobes stay low until the edge at which `blast_n` is sampled low, and are released on that edge.
- R7: `ready` is high for exactly one cycle, starting on the edge that releases the strobes; at that point all strobes are high.
- R8: While a cycle is active, changes on `ads_n`, `addr`, `wr_rd` and `hold_cycles` have no effect on the outputs. A new cycle can start at the edge that ends the `ready` cycle.
- R9: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe from the master, active low |
| blast_n | input | 1 | Burst-last from the master, active low |
| wr_rd | input | 1 | Direction: 1 write, 0 read |
| addr | input | ADDR_W | Word address |
| hold_cycles | input | CNT_W | Strobe active time in clock cycles (0 acts as 1) |
| per_cs_n | output | 1 | Peripheral chip select, active low |
| latch_cs_n | output | 1 | Latch-region select, active low |
| inbuf_cs_n | output | 1 | Input-buffer-region select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ready | output | 1 | One-cycle completion pulse to the master |

## Verification
The bench builds the block with a 3-bit strobe-length field, so both the zero length and the largest length of 7 are driven. A burst-last that arrives 9 cycles after the start therefore lands beyond any possible strobe time.

The peripheral page is moved to 2. As a result, page-0 addresses fall outside every region and exercise the no-strobe completion path. The latch and input-buffer words sit at 0x8000 and 0x8001, where they differ in one bit, which checks exact-match decoding.

// File: rtl/lbsg_pkg.sv
package lbsg_pkg;
  typedef enum logic [1:0] {
    RG_NONE  = 2'd0,
    RG_PER   = 2'd1,
    RG_LATCH = 2'd2,
    RG_INBUF = 2'd3
  } region_t;

  localparam int unsigned NUM_CS = 3;
endpackage

// File: rtl/lbsg_decode.sv
module lbsg_decode
  import lbsg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 4,
  parameter logic [PAGE_W-1:0] PER_PAGE   = '0,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'h8000,
  parameter logic [ADDR_W-1:0] INBUF_ADDR = 16'h8001
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region
);
  localparam int unsigned PAGE_LSB = ADDR_W - PAGE_W;

  always_comb begin
    if (addr[ADDR_W-1:PAGE_LSB] == PER_PAGE)
      region = RG_PER;
    else if (addr == LATCH_ADDR)
      region = RG_LATCH;
    else if (addr == INBUF_ADDR)
      region = RG_INBUF;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/lbsg_timer.sv
module lbsg_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lbus_strobe_gen.sv
module lbus_strobe_gen
  import lbsg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned PAGE_W     = 4,
  parameter logic [PAGE_W-1:0] PER_PAGE   = '0,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 16'h8000,
  parameter logic [ADDR_W-1:0] INBUF_ADDR = 16'h8001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n,
  input  logic              blast_n,
  input  logic              wr_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  hold_cycles,
  output logic              per_cs_n,
  output logic              latch_cs_n,
  output logic              inbuf_cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ready
);
  region_t             region;
  logic [NUM_CS-1:0]   cs_dec_n;
  logic [NUM_CS-1:0]   cs_q;
  logic                rd_q, wr_q, ready_q;
  logic                active, last_seen, expired;
  logic                start;
  logic [CNT_W-1:0]    load_val;
  logic                mapped;

  lbsg_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PER_PAGE(PER_PAGE),
    .LATCH_ADDR(LATCH_ADDR), .INBUF_ADDR(INBUF_ADDR)
  ) u_decode (
    .addr   (addr),
    .region (region)
  );

  // One select line per region; index i serves region code i+1.
  for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
    assign cs_dec_n[gi] = (region != region_t'(gi + 1));
  end

  assign mapped   = (region != RG_NONE);
  assign start    = !active && !ads_n;
  // Counter runs from N-1 down to zero, giving N cycles of strobe.
  assign load_val = (hold_cycles == '0) ? '0 : hold_cycles - 1'b1;

  lbsg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (load_val),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      last_seen <= 1'b0;
      cs_q      <= '1;
      rd_q      <= 1'b1;
      wr_q      <= 1'b1;
      ready_q   <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (start) begin
        active    <= 1'b1;
        last_seen <= !blast_n;
        cs_q      <= cs_dec_n;
        rd_q      <= !(mapped && !wr_rd);
        wr_q      <= !(mapped && wr_rd);
      end else if (active) begin
        last_seen <= last_seen || !blast_n;
        if (expired && (last_seen || !blast_n)) begin
          active  <= 1'b0;
          cs_q    <= '1;
          rd_q    <= 1'b1;
          wr_q    <= 1'b1;
          ready_q <= 1'b1;
        end
      end
    end
  end

  assign per_cs_n   = cs_q[0];
  assign latch_cs_n = cs_q[1];
  assign inbuf_cs_n = cs_q[2];
  assign rd_n       = rd_q;
  assign wr_n       = wr_q;
  assign ready      = ready_q;
endmodule

// File: rtl/lbsg_chk.sv
module lbsg_chk (
  input logic       clk,
  input logic       rst,
  input logic       ads_n,
  input logic       active,
  input logic       expired,
  input logic [2:0] cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ready
);
  p_one_cs_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  p_rdwr_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!active && !ads_n) |=> active);

  p_no_early_release_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !expired) |=> active);

  p_ready_after_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(expired));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  p_release_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (&cs_n && rd_n && wr_n && !active));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> ($stable(cs_n) && $stable(rd_n) && $stable(wr_n)));
endmodule

bind lbus_strobe_gen lbsg_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ads_n   (ads_n),
  .active  (active),
  .expired (expired),
  .cs_n    (cs_q),
  .rd_n    (rd_q),
  .wr_n    (wr_q),
  .ready   (ready_q)
);

// File: tb/tb_lbus_strobe_gen.sv
module tb_lbus_strobe_gen;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 3;
  localparam logic [3:0]  PPAGE  = 4'h2;
  localparam logic [15:0] LADDR  = 16'h8000;
  localparam logic [15:0] IADDR  = 16'h8001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ads_n = 1'b1, blast_n = 1'b1, wr_rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  hold_cycles = '0;
  logic per_cs_n, latch_cs_n, inbuf_cs_n, rd_n, wr_n, ready;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lbus_strobe_gen #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(4), .PER_PAGE(PPAGE),
    .LATCH_ADDR(LADDR), .INBUF_ADDR(IADDR)
  ) dut (
    .clk(clk), .rst(rst), .ads_n(ads_n), .blast_n(blast_n), .wr_rd(wr_rd),
    .addr(addr), .hold_cycles(hold_cycles), .per_cs_n(per_cs_n),
    .latch_cs_n(latch_cs_n), .inbuf_cs_n(inbuf_cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: expected outputs after each edge.
  bit m_busy = 0, m_last = 0;
  int m_left = 0;
  logic [2:0] e_cs = 3'b111;
  logic e_rd = 1, e_wr = 1, e_rdy = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_last = 0; e_cs = 3'b111; e_rd = 1; e_wr = 1; e_rdy = 0;
    end else begin
      e_rdy = 0;
      if (!m_busy) begin
        if (!ads_n) begin
          m_busy = 1;
          m_left = (hold_cycles == 0) ? 1 : int'(hold_cycles);
          m_last = !blast_n;
          if (addr[15:12] == PPAGE)  e_cs = 3'b110;
          else if (addr == LADDR)    e_cs = 3'b101;
          else if (addr == IADDR)    e_cs = 3'b011;
          else                       e_cs = 3'b111;
          e_rd = !(e_cs != 3'b111 && !wr_rd);
          e_wr = !(e_cs != 3'b111 && wr_rd);
        end
      end else begin
        m_left = m_left - 1;
        if (!blast_n) m_last = 1;
        if (m_left <= 0 && m_last) begin
          m_busy = 0; e_cs = 3'b111; e_rd = 1; e_wr = 1; e_rdy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check({inbuf_cs_n, latch_cs_n, per_cs_n} == e_cs, "R3 R9 chip selects",
            int'({inbuf_cs_n, latch_cs_n, per_cs_n}), int'(e_cs));
      check(rd_n == e_rd, "R4 R5 R6 read strobe", int'(rd_n), int'(e_rd));
      check(wr_n == e_wr, "R4 R5 R6 write strobe", int'(wr_n), int'(e_wr));
      check(ready == e_rdy, "R7 ready", int'(ready), int'(e_rdy));
    end
  end

  // One transfer: blast_n low for one cycle, d cycles after the start edge.
  task automatic xfer(input logic [15:0] a, input bit w, input int hold,
                      input int d, input string tag);
    int low = 0;
    int rdy = 0;
    int n = (hold == 0) ? 1 : hold;
    int expect_low;
    bit mapped = (a[15:12] == PPAGE) || (a == LADDR) || (a == IADDR);
    expect_low = mapped ? ((d > n) ? d : n) : 0;
    @(negedge clk);
    ads_n = 0; addr = a; wr_rd = w; hold_cycles = CNT_W'(hold);
    blast_n = (d == 0) ? 1'b0 : 1'b1;
    for (int k = 1; k < 40 && rdy == 0; k++) begin
      @(negedge clk);
      ads_n = 1; blast_n = (k == d) ? 1'b0 : 1'b1;
      if (!rd_n || !wr_n) low++;
      if (ready) rdy++;
    end
    blast_n = 1;
    check(low == expect_low, tag, low, expect_low);
    check(rdy == 1, tag, rdy, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(per_cs_n && latch_cs_n && inbuf_cs_n, "R1 chip selects in reset", 0, 1);
    check(rd_n && wr_n && !ready, "R1 strobes and ready in reset", 0, 1);
    rst = 0;
    // R2 R5: peripheral read, 3 cycles, blast with start
    xfer(16'h2123, 0, 3, 0, "R2 R5 peripheral read length");
    // R4 R5: latch write, length 0 acts as 1
    xfer(LADDR, 1, 0, 0, "R4 R5 latch write zero length");
    // R5: maximum length, blast before expiry
    xfer(IADDR, 0, 7, 2, "R5 input buffer read max length");
    // R6: blast after expiry extends strobe
    xfer(16'h2FFE, 1, 2, 9, "R6 late burst-last extends strobe");
    xfer(16'h2000, 0, 1, 4, "R6 late burst-last short hold");
    // R3: unmapped address, no strobes but ready
    xfer(16'h0123, 1, 3, 0, "R3 unmapped completes without strobe");
    xfer(16'h8002, 0, 2, 0, "R3 near-miss latch address unmapped");
    // R8: inputs changed mid-cycle are ignored
    @(negedge clk);
    ads_n = 0; addr = 16'h2010; wr_rd = 0; hold_cycles = 3'd4; blast_n = 0;
    @(negedge clk);
    ads_n = 0; addr = LADDR; wr_rd = 1; hold_cycles = 3'd1; blast_n = 1;
    @(negedge clk);
    check(!per_cs_n && latch_cs_n && !rd_n && wr_n, "R8 mid-cycle inputs ignored",
          int'({per_cs_n, latch_cs_n, rd_n, wr_n}), 4'b0101);
    ads_n = 1;
    repeat (4) @(negedge clk);
    // R8: back-to-back cycles with ads_n held low
    ads_n = 0; addr = IADDR; wr_rd = 1; hold_cycles = 3'd2; blast_n = 0;
    repeat (9) @(negedge clk);
    ads_n = 1; blast_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset mid-cycle returns strobes high
    ads_n = 0; addr = 16'h2222; hold_cycles = 3'd5;
    @(negedge clk);
    ads_n = 1; rst = 1;
    @(negedge clk);
    check(per_cs_n && rd_n && wr_n && !ready, "R1 reset during cycle", 0, 1);
    rst = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule